// File: doc/BRIEF.md
# Block-Command Disk Controller

This block is a memory-mapped storage controller that moves whole 512-byte blocks between a CPU-visible data window and an internal block store. The block store is a small on-chip memory array that takes the place of a disk. Software works in three steps. It first fills the window or prepares to read it. It then writes a block number. Last, it writes a single command byte. A write command copies the window into the selected block. A read command copies the selected block into the window.

The command byte is also the status byte. While a transfer runs, it reads back the active command. When the transfer ends, the hardware writes zero into it, so software polls that byte until it reads zero. The transfer engine waits a fixed start latency and then moves one byte per clock. A command byte that is not valid is rejected with an error code, and no data moves.

All CPU accesses use one simple synchronous bus. A write is a single-cycle strobe. Read data is registered and returned one cycle after the address is presented.

Top module: `dc_block_ctrl`

## Requirements
- R1: Synchronous reset sets the command/status byte to 0x00 and the 16-bit block number register to 0.
- R2: The data window covers 0xF900 to 0xFAFF. The byte at window offset k is written by a bus write to 0xF900+k and read by a bus read of that address. Reads of addresses that map to nothing return 0x00.
- R3: The block number register is 16 bits wide and little-endian. The low byte is at 0xF822 and the high byte is at 0xF823. Both bytes read back what was written.
- R4: Writing 0x57 (ASCII 'W') to the command byte at 0xF820 copies all 512 window bytes into the selected block. Window offset k goes to block byte k.
- R5: Writing 0x52 (ASCII 'R') to 0xF820 copies all 512 bytes of the selected block into the window. Block byte k goes to window offset k.
- R6: While a transfer runs, 0xF820 reads back the accepted command. The status byte becomes 0x00 at the 514th clock edge after the edge that accepted the command: 2 start cycles plus 512 byte moves.
- R7: While a transfer runs, bus writes to the window, to the block number bytes and to the command byte have no effect.
- R8: When idle, writing any command value other than 0x57, 0x52 or 0x00 sets the status byte to 0xFF and moves no data. Writing 0x00 sets the status to 0x00 and moves no data.
- R9: The store holds 8 blocks. The block addressed is the block number modulo 8, taken from its three low bits.
- R10: The bus returns read data on bus_rdata one clock after the edge at which the address was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wen | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data for the address sampled at the previous edge |

## Verification
Every bus read is returned at the clock edge that follows the one that sampled its address. The bench therefore presents the address after a falling edge and samples bus_rdata at the next falling edge. For a command, the status byte clears at the 514th edge after acceptance. Because of the registered read path, a continuous poll of 0xF820 still shows the command after edge 514 and first shows 0x00 after edge 515; one directed test checks both of those cycles exactly. The other transfers poll the status until it reads 0x00. They then compare all 512 window bytes with a pattern computed in the bench. This includes the block-number aliases that wrap modulo 8, and the rejected or ignored writes made during a transfer or made with an invalid command.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_MOVE} dc_state_e;

   localparam logic [7:0] CMD_WR   = 8'h57;
   localparam logic [7:0] CMD_RD   = 8'h52;
   localparam logic [7:0] CMD_NONE = 8'h00;
   localparam logic [7:0] STAT_BAD = 8'hFF;
endpackage

// File: rtl/dc_buf.sv
module dc_buf #(
   parameter int BLK_BYTES = 512,
   localparam int IDXW = $clog2(BLK_BYTES)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cpu_we,
   input  logic [IDXW-1:0] cpu_idx,
   input  logic [7:0]      cpu_wdata,
   output logic [7:0]      cpu_rdata,
   input  logic            eng_we,
   input  logic [IDXW-1:0] eng_idx,
   input  logic [7:0]      eng_wdata,
   output logic [7:0]      eng_rdata
);
   logic [7:0] mem [BLK_BYTES];

   initial assert (BLK_BYTES >= 2 && (1 << IDXW) == BLK_BYTES)
      else $error("dc_buf: BLK_BYTES must be a power of two");

   always_ff @(posedge clk) begin
      if (eng_we)
         mem[eng_idx] <= eng_wdata;
      else if (cpu_we)
         mem[cpu_idx] <= cpu_wdata;
   end

   assign cpu_rdata = mem[cpu_idx];
   assign eng_rdata = mem[eng_idx];

   // R7: the CPU port and the engine never write in the same cycle
   a_r7_single_writer: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cpu_we, eng_we}));
endmodule

// File: rtl/dc_store.sv
module dc_store #(
   parameter int BLK_BYTES = 512,
   parameter int NUM_BLKS  = 8,
   localparam int IDXW = $clog2(BLK_BYTES),
   localparam int SELW = $clog2(NUM_BLKS)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [SELW-1:0] sel,
   input  logic [IDXW-1:0] idx,
   input  logic [7:0]      wdata,
   output logic [7:0]      rdata
);
   logic [7:0] bank_rd [NUM_BLKS];

   initial assert (NUM_BLKS >= 2 && (1 << SELW) == NUM_BLKS)
      else $error("dc_store: NUM_BLKS must be a power of two, at least 2");

   for (genvar b = 0; b < NUM_BLKS; b++) begin : g_bank
      logic [7:0] mem [BLK_BYTES];
      always_ff @(posedge clk) begin
         if (we && sel == SELW'(b))
            mem[idx] <= wdata;
      end
      assign bank_rd[b] = mem[idx];
   end

   assign rdata = bank_rd[sel];
endmodule

// File: rtl/dc_seq.sv
module dc_seq
   import dc_pkg::*;
#(
   parameter int BLK_BYTES = 512,
   parameter int START_LAT = 2,
   localparam int IDXW = $clog2(BLK_BYTES),
   localparam int WCW  = (START_LAT > 1) ? $clog2(START_LAT) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cmd_we,
   input  logic [7:0]      cmd_wdata,
   output logic [7:0]      status,
   output logic            busy,
   output logic            move_en,
   output logic            move_rd,
   output logic [IDXW-1:0] move_idx
);
   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BLK_BYTES - 1);
   localparam logic [WCW-1:0]  LAST_W   = WCW'((START_LAT > 0) ? START_LAT - 1 : 0);

   dc_state_e      state;
   logic [WCW-1:0] wcnt;
   logic           cmd_ok;

   initial assert (START_LAT >= 0 && START_LAT <= 16)
      else $error("dc_seq: START_LAT out of range");

   assign cmd_ok = (cmd_wdata == CMD_WR) || (cmd_wdata == CMD_RD);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         status   <= CMD_NONE;
         wcnt     <= '0;
         move_idx <= '0;
         move_rd  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cmd_we) begin
                  if (cmd_ok) begin
                     status   <= cmd_wdata;
                     move_rd  <= (cmd_wdata == CMD_RD);
                     wcnt     <= '0;
                     move_idx <= '0;
                     state    <= (START_LAT == 0) ? ST_MOVE : ST_WAIT;
                  end else if (cmd_wdata == CMD_NONE) begin
                     status <= CMD_NONE;
                  end else begin
                     status <= STAT_BAD;
                  end
               end
            end
            ST_WAIT: begin
               wcnt <= wcnt + 1'b1;
               if (wcnt == LAST_W)
                  state <= ST_MOVE;
            end
            ST_MOVE: begin
               move_idx <= move_idx + 1'b1;
               if (move_idx == LAST_IDX) begin
                  state  <= ST_IDLE;
                  status <= CMD_NONE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign move_en = (state == ST_MOVE);

   // R6: while busy the status byte holds the accepted command
   a_r6_busy_shows_cmd: assert property (@(posedge clk) disable iff (rst)
      busy |-> (status == CMD_WR || status == CMD_RD));

   // R6: after the last byte move the status is zero and the engine idle
   a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
      (move_en && move_idx == LAST_IDX) |=> (status == CMD_NONE && !busy));

   // R8: an invalid command while idle gives 0xFF and starts nothing
   a_r8_bad_cmd: assert property (@(posedge clk) disable iff (rst)
      (!busy && cmd_we && !cmd_ok && cmd_wdata != CMD_NONE)
         |=> (status == STAT_BAD && !busy));

   // R7: a command write during a transfer does not change the command
   a_r7_cmd_locked: assert property (@(posedge clk) disable iff (rst)
      (busy && !(move_en && move_idx == LAST_IDX)) |=> $stable(status));
endmodule

// File: rtl/dc_block_ctrl.sv
module dc_block_ctrl
   import dc_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              BLK_BYTES = 512,
   parameter int              NUM_BLKS  = 8,
   parameter int              START_LAT = 2,
   parameter logic [15:0]     BUF_BASE  = 16'hF900,
   parameter logic [15:0]     CMD_ADDR  = 16'hF820,
   parameter logic [15:0]     BLK_ADDR  = 16'hF822
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);
   localparam int IDXW = $clog2(BLK_BYTES);
   localparam int SELW = $clog2(NUM_BLKS);
   localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'(BUF_BASE);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_ADDR);
   localparam logic [ADDR_W-1:0] A_BLO  = ADDR_W'(BLK_ADDR);
   localparam logic [ADDR_W-1:0] A_BHI  = ADDR_W'(BLK_ADDR) + 1'b1;
   localparam logic [ADDR_W-1:0] BUF_LEN = ADDR_W'(BLK_BYTES);

   logic [ADDR_W-1:0] buf_off;
   logic              in_buf;
   logic [15:0]       blk_q;
   logic [7:0]        status;
   logic              busy, move_en, move_rd;
   logic [IDXW-1:0]   move_idx;
   logic [7:0]        cpu_rd, eng_rd, store_rd;

   initial assert (ADDR_W >= IDXW + 1 && ADDR_W <= 16)
      else $error("dc_block_ctrl: ADDR_W out of range");

   assign buf_off = bus_addr - A_BUF;
   assign in_buf  = (bus_addr >= A_BUF) && (buf_off < BUF_LEN);

   always_ff @(posedge clk) begin
      if (rst) begin
         blk_q <= '0;
      end else if (bus_wen && !busy) begin
         if (bus_addr == A_BLO) blk_q[7:0]  <= bus_wdata;
         if (bus_addr == A_BHI) blk_q[15:8] <= bus_wdata;
      end
   end

   dc_seq #(.BLK_BYTES(BLK_BYTES), .START_LAT(START_LAT)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .cmd_we    (bus_wen && bus_addr == A_CMD),
      .cmd_wdata (bus_wdata),
      .status    (status),
      .busy      (busy),
      .move_en   (move_en),
      .move_rd   (move_rd),
      .move_idx  (move_idx)
   );

   dc_buf #(.BLK_BYTES(BLK_BYTES)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .cpu_we    (bus_wen && in_buf && !busy),
      .cpu_idx   (buf_off[IDXW-1:0]),
      .cpu_wdata (bus_wdata),
      .cpu_rdata (cpu_rd),
      .eng_we    (move_en && move_rd),
      .eng_idx   (move_idx),
      .eng_wdata (store_rd),
      .eng_rdata (eng_rd)
   );

   dc_store #(.BLK_BYTES(BLK_BYTES), .NUM_BLKS(NUM_BLKS)) u_store (
      .clk   (clk),
      .we    (move_en && !move_rd),
      .sel   (blk_q[SELW-1:0]),
      .idx   (move_idx),
      .wdata (eng_rd),
      .rdata (store_rd)
   );

   always_ff @(posedge clk) begin
      if (rst)                    bus_rdata <= '0;
      else if (in_buf)            bus_rdata <= cpu_rd;
      else if (bus_addr == A_CMD) bus_rdata <= status;
      else if (bus_addr == A_BLO) bus_rdata <= blk_q[7:0];
      else if (bus_addr == A_BHI) bus_rdata <= blk_q[15:8];
      else                        bus_rdata <= '0;
   end

   // R1: reset clears the status byte and the block number
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (status == CMD_NONE && blk_q == 16'h0000));

   // R7: the block number cannot change during a transfer
   a_r7_blk_hold: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(blk_q));
endmodule

// File: tb/test_dc_block_ctrl.sv
module test_dc_block_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dc_block_ctrl i_dc_block_ctrl (
      .clk(clk), .rst(rst), .bus_addr(bus_addr),
      .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   typedef struct packed {
      logic [15:0] wblk;
      logic [15:0] rblk;
      logic [7:0]  seed;
   } vec_t;

   // write block, alias used to read it back (wraps modulo 8), pattern seed
   localparam vec_t VECS [5] = '{
      '{16'h0000, 16'h0008, 8'h11},
      '{16'h0003, 16'h0013, 8'h5A},
      '{16'h0007, 16'h0107, 8'hC3},
      '{16'h0009, 16'h0001, 8'h2E},
      '{16'h0005, 16'h0005, 8'h90}
   };

   function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
      return seed ^ 8'(i * 7) ^ 8'(i >> 8);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // tasks start just after a falling edge
   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic set_blk(input logic [15:0] b);
      bus_write(16'hF822, b[7:0]);
      bus_write(16'hF823, b[15:8]);
   endtask

   task automatic fill_buf(input logic [7:0] seed);
      for (int i = 0; i < 512; i++) bus_write(16'hF900 + 16'(i), pat(seed, i));
   endtask

   task automatic wait_idle(input string req);
      logic [7:0] s;
      int n = 0;
      bus_addr = 16'hF820;
      do begin
         @(negedge clk);
         s = bus_rdata;
         n++;
      end while (s != 8'h00 && n < 2000);
      chk(req, s, 0);
   endtask

   task automatic cmp_buf(input string req, input logic [7:0] seed);
      logic [7:0] d;
      int nmis = 0;
      for (int i = 0; i < 512; i++) begin
         bus_read(16'hF900 + 16'(i), d);
         if (d != pat(seed, i)) nmis++;
      end
      chk(req, nmis, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state, R10 registered read
      bus_read(16'hF820, d); chk("R1 status", d, 8'h00);
      bus_read(16'hF822, d); chk("R1 blk lo", d, 8'h00);
      bus_read(16'hF823, d); chk("R1 blk hi", d, 8'h00);

      // R2 unmapped and window write/read
      bus_read(16'hF821, d); chk("R2 unmapped", d, 8'h00);
      bus_write(16'hF900, 8'hA5);
      bus_write(16'hFAFF, 8'h3C);
      bus_read(16'hF900, d); chk("R2 first byte", d, 8'hA5);
      bus_read(16'hFAFF, d); chk("R2 last byte", d, 8'h3C);
      bus_read(16'hFB00, d); chk("R2 past window", d, 8'h00);

      // R3 little-endian block number
      set_blk(16'hBEEF);
      bus_read(16'hF822, d); chk("R3 lo", d, 8'hEF);
      bus_read(16'hF823, d); chk("R3 hi", d, 8'hBE);

      // R10: after a read of one address, the next edge shows the next one
      bus_addr = 16'hF822;
      @(posedge clk); #1 bus_addr = 16'hF823;
      @(negedge clk); chk("R10 one-cycle", bus_rdata, 8'hEF);
      @(negedge clk); chk("R10 next", bus_rdata, 8'hBE);

      // table walk: write all blocks, then read back via aliases (R4 R5 R9)
      for (int v = 0; v < 5; v++) begin
         fill_buf(VECS[v].seed);
         set_blk(VECS[v].wblk);
         bus_write(16'hF820, 8'h57);
         wait_idle("R4 write done");
      end
      for (int v = 0; v < 5; v++) begin
         fill_buf(8'hFF);
         set_blk(VECS[v].rblk);
         bus_write(16'hF820, 8'h52);
         wait_idle("R5 read done");
         cmp_buf("R9 R5 readback", VECS[v].seed);
      end

      // R6 exact completion timing
      set_blk(16'h0006);
      bus_write(16'hF820, 8'h57);
      bus_addr = 16'hF820;
      repeat (514) @(negedge clk);
      chk("R6 still busy at 514", bus_rdata, 8'h57);
      @(negedge clk);
      chk("R6 done at 515", bus_rdata, 8'h00);

      // R7 writes ignored while busy
      fill_buf(8'h44);
      set_blk(16'h0002);
      bus_write(16'hF820, 8'h57);
      bus_write(16'hF900, 8'hEE);
      bus_write(16'hF822, 8'h05);
      bus_write(16'hF820, 8'h52);
      bus_read(16'hF820, d); chk("R7 cmd kept", d, 8'h57);
      wait_idle("R7 done");
      bus_read(16'hF822, d); chk("R7 blk kept", d, 8'h02);
      bus_read(16'hF900, d); chk("R7 buf kept", d, pat(8'h44, 0));
      fill_buf(8'h00);
      bus_write(16'hF820, 8'h52);
      wait_idle("R7 readback done");
      cmp_buf("R7 block intact", 8'h44);

      // R8 invalid command: 0xFF, no transfer
      fill_buf(8'h77);
      set_blk(16'h0000);
      bus_write(16'hF820, 8'h41);
      bus_read(16'hF820, d); chk("R8 bad status", d, 8'hFF);
      repeat (600) @(negedge clk);
      bus_read(16'hF820, d); chk("R8 bad stays", d, 8'hFF);
      bus_read(16'hF905, d); chk("R8 buf untouched", d, pat(8'h77, 5));
      bus_write(16'hF820, 8'h00);
      bus_read(16'hF820, d); chk("R8 zero cmd", d, 8'h00);
      bus_read(16'hF905, d); chk("R8 zero no move", d, pat(8'h77, 5));
      bus_write(16'hF820, 8'h52);
      wait_idle("R8 read done");
      cmp_buf("R8 block0 intact", VECS[0].seed);

      // R1 reset again mid-state
      set_blk(16'h1234);
      bus_write(16'hF820, 8'h99);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      bus_read(16'hF820, d); chk("R1 status after reset", d, 8'h00);
      bus_read(16'hF823, d); chk("R1 blk after reset", d, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule